// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a synchronous DRAM. On each rising clock edge it samples the select, row-strobe, column-strobe and write-enable pins and turns them into one decoded command. It also follows whether each of the two banks holds an open row and keeps the burst length, burst ordering and read latency fields of the mode register. Downstream logic (array control, data path, latency pipes) uses the registered command strobe, the bank/row/column fields and the per-bank open flags. It does not need to decode the pins again.

Rules are enforced on the spot. A command that breaks the bank-state rules is dropped and flagged on a one-cycle error output. A mode write that carries a reserved code is stored anyway and flagged. The top address bit chooses the bank. Address bit 10 has two uses: on column commands it requests auto-precharge, and on a precharge it closes both banks.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n} sampled low-active: activate 0011, read 0101, write 0100, precharge 0010, burst stop 0110, refresh 0001, mode set 0000, no-op 0111. On cmd_o they are coded NOP=0, ACT=1, RD=2, WR=3, PRE=4, BST=5, REF=6, SREF=7, MRS=8. An accepted command drives cmd_valid_o high for exactly the cycle after its sampling edge. A no-op produces no strobe.
- R2: With cs_ni high, the block produces no strobe, no error and no change of bank state, whatever the other pins carry.
- R3: A command is taken only if cke_i was high at the previous rising edge. With that condition met, the refresh code is auto refresh (6) when cke_i is high and self-refresh entry (7) when cke_i is low.
- R4: With each accepted command, bank_o takes addr_i[11], row_o takes addr_i[10:0] and col_o takes addr_i[7:0]. These outputs, cmd_o and auto_pre_o hold while no command is accepted.
- R5: An activate opens the bank named by addr_i[11] (0 = bank A, bit 0 of bank_open_o; 1 = bank B, bit 1). An activate to a bank that is already open raises err_o and is dropped.
- R6: A precharge with addr_i[10] high closes both banks. With addr_i[10] low it closes only the bank named by addr_i[11]. A precharge of a closed bank is legal.
- R7: A read or write to an open bank is accepted. auto_pre_o then equals addr_i[10], and when that bit is high the addressed bank is closed from that edge on.
- R8: A read or write to a closed bank raises err_o, gives no strobe and changes nothing else.
- R9: A mode set with both banks closed loads burst length from addr_i[2:0], burst ordering from addr_i[3] and read latency from addr_i[6:4]. After reset these fields are 0, 0 and 2.
- R10: A mode set while any bank is open raises err_o and leaves the mode fields unchanged.
- R11: A mode set is flagged on err_o but still stored and strobed if it carries a reserved code: latency other than 2 or 3, burst length code 4 to 6, or code 7 (full page) together with interleaved ordering.
- R12: An auto refresh or self-refresh entry while any bank is open raises err_o and is dropped.
- R13: In reset, cmd_valid_o, err_o, auto_pre_o and bank_open_o are 0, cmd_o is NOP and the mode fields hold their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 12 | Address; bit 11 bank, bit 10 auto-precharge / all-banks |
| cmd_valid_o | output | 1 | One-cycle strobe for an accepted command |
| cmd_o | output | 4 | Code of the last accepted command |
| bank_o | output | 1 | Bank of the last accepted command |
| row_o | output | 11 | Row field of the last accepted command |
| col_o | output | 8 | Column field of the last accepted command |
| auto_pre_o | output | 1 | Last accepted read/write requested auto-precharge |
| bank_open_o | output | 2 | Open flag per bank |
| burst_len_o | output | 3 | Burst length code |
| burst_seq_o | output | 1 | Burst ordering, 1 = interleaved |
| cas_lat_o | output | 3 | Read latency code |
| err_o | output | 1 | One-cycle flag for an illegal command or reserved mode code |

## Verification
Every result here takes one register stage. The strobe, command code, address fields, error flag, bank flags and mode fields all change on the same rising edge that samples the command. The one exception is the clock-enable qualification, which looks back one further edge. The bench therefore drives the pins on a falling edge and compares all outputs a quarter period after the next rising edge, before it applies the next command. The clock-enable cases put a low cycle in front of the command under test, so the command falls in the window where the previous-edge rule applies.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_PRE  = 4'd4,
    CMD_BST  = 4'd5,
    CMD_REF  = 4'd6,
    CMD_SREF = 4'd7,
    CMD_MRS  = 4'd8
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
(
  input  logic cke_prev_i,
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (cke_prev_i && !cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b110:  cmd_o = CMD_BST;
        3'b001:  cmd_o = cke_i ? CMD_REF : CMD_SREF;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  cmd_e                 cmd_i,
  input  logic                 accept_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 a10_i,
  output logic [NUM_BANKS-1:0] open_o,
  output logic                 sel_open_o,
  output logic                 any_open_o
);
  logic [NUM_BANKS-1:0] open_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit, set, clr;
    assign hit = (bank_i == BANK_W'(b));
    assign set = accept_i && (cmd_i == CMD_ACT) && hit;
    // a10 means "all banks" on precharge, "auto-precharge" on column commands
    assign clr = accept_i &&
                 (((cmd_i == CMD_PRE) && (a10_i || hit)) ||
                  ((cmd_i == CMD_RD || cmd_i == CMD_WR) && a10_i && hit));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  open_q[b] <= 1'b0;
      else if (set) open_q[b] <= 1'b1;
      else if (clr) open_q[b] <= 1'b0;
    end
  end

  assign open_o     = open_q;
  assign sel_open_o = open_q[bank_i];
  assign any_open_o = |open_q;
endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg #(
  parameter int BL_W = 3,
  parameter int CL_W = 3,
  parameter logic [CL_W-1:0] CL_RESET = CL_W'(2)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [6:0]      data_i,
  output logic [BL_W-1:0] burst_len_o,
  output logic            burst_seq_o,
  output logic [CL_W-1:0] cas_lat_o,
  output logic            rsvd_o
);
  logic [BL_W-1:0] bl_in;
  logic            bt_in;
  logic [CL_W-1:0] cl_in;

  assign bl_in = data_i[BL_W-1:0];
  assign bt_in = data_i[3];
  assign cl_in = data_i[4 +: CL_W];

  // reserved: latency not 2/3, length 4..6, full page with interleave
  assign rsvd_o = !(cl_in == CL_W'(2) || cl_in == CL_W'(3)) ||
                  (bl_in >= BL_W'(4) && bl_in <= BL_W'(6)) ||
                  (bl_in == BL_W'(7) && bt_in);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_len_o <= '0;
      burst_seq_o <= 1'b0;
      cas_lat_o   <= CL_RESET;
    end else if (wr_i) begin
      burst_len_o <= bl_in;
      burst_seq_o <= bt_in;
      cas_lat_o   <= cl_in;
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = ROW_W + BANK_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 cmd_valid_o,
  output logic [3:0]           cmd_o,
  output logic [BANK_W-1:0]    bank_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [COL_W-1:0]     col_o,
  output logic                 auto_pre_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic [2:0]           burst_len_o,
  output logic                 burst_seq_o,
  output logic [2:0]           cas_lat_o,
  output logic                 err_o
);
  localparam int AP_BIT = ROW_W - 1;

  logic              cke_q;
  cmd_e              dec_cmd;
  logic [BANK_W-1:0] sel_bank;
  logic              ap_bit, sel_open, any_open, legal, illegal, mode_rsvd, mode_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b0;
    else         cke_q <= cke_i;
  end

  sdram_cmd_decode u_dec (
    .cke_prev_i(cke_q),
    .cke_i     (cke_i),
    .cs_ni     (cs_ni),
    .ras_ni    (ras_ni),
    .cas_ni    (cas_ni),
    .we_ni     (we_ni),
    .cmd_o     (dec_cmd)
  );

  assign sel_bank = addr_i[ADDR_W-1 -: BANK_W];
  assign ap_bit   = addr_i[AP_BIT];

  always_comb begin
    unique case (dec_cmd)
      CMD_ACT:                    legal = !sel_open;
      CMD_RD, CMD_WR:             legal = sel_open;
      CMD_MRS, CMD_REF, CMD_SREF: legal = !any_open;
      CMD_PRE, CMD_BST:           legal = 1'b1;
      default:                    legal = 1'b0;
    endcase
  end
  assign illegal = (dec_cmd != CMD_NOP) && !legal;
  assign mode_wr = legal && (dec_cmd == CMD_MRS);

  sdram_bank_track #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (dec_cmd),
    .accept_i  (legal),
    .bank_i    (sel_bank),
    .a10_i     (ap_bit),
    .open_o    (bank_open_o),
    .sel_open_o(sel_open),
    .any_open_o(any_open)
  );

  sdram_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (mode_wr),
    .data_i     (addr_i[6:0]),
    .burst_len_o(burst_len_o),
    .burst_seq_o(burst_seq_o),
    .cas_lat_o  (cas_lat_o),
    .rsvd_o     (mode_rsvd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      err_o       <= 1'b0;
      cmd_o       <= 4'(CMD_NOP);
      bank_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
      auto_pre_o  <= 1'b0;
    end else begin
      cmd_valid_o <= legal;
      err_o       <= illegal || (mode_wr && mode_rsvd);
      if (legal) begin
        cmd_o      <= 4'(dec_cmd);
        bank_o     <= sel_bank;
        row_o      <= addr_i[ROW_W-1:0];
        col_o      <= addr_i[COL_W-1:0];
        auto_pre_o <= (dec_cmd == CMD_RD || dec_cmd == CMD_WR) && ap_bit;
      end
    end
  end

  // R2
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!cmd_valid_o && !err_o && $stable(bank_open_o)));

  // R5
  act_open_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_cmd == CMD_ACT && sel_open) |=> (err_o && !cmd_valid_o && $stable(bank_open_o)));

  // R6
  pre_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_cmd == CMD_PRE && ap_bit) |=> (bank_open_o == '0));

  // R8
  col_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dec_cmd == CMD_RD || dec_cmd == CMD_WR) && !sel_open) |=> (err_o && !cmd_valid_o));

  // R10
  mrs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_cmd == CMD_MRS && any_open) |=> (err_o && $stable(cas_lat_o) && $stable(burst_len_o)));

  // R12
  ref_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dec_cmd == CMD_REF || dec_cmd == CMD_SREF) && any_open) |=> (err_o && !cmd_valid_o));
endmodule

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;
  localparam time CLK_PERIOD = 10ns;

  // ctl = {cke, cs_n, ras_n, cas_n, we_n}
  localparam logic [4:0] C_ACT = 5'b10011, C_RD = 5'b10101, C_WR = 5'b10100,
                         C_PRE = 5'b10010, C_BST = 5'b10110, C_REF = 5'b10001,
                         C_MRS = 5'b10000, C_NOP = 5'b10111, C_DES = 5'b11011;

  typedef struct packed {
    logic [4:0]  ctl;
    logic [11:0] addr;
    logic [3:0]  req;
    logic        v;
    logic [3:0]  cmd;
    logic        ap;
    logic [1:0]  open;
    logic        err;
    logic [2:0]  bl;
    logic        bt;
    logic [2:0]  cl;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{C_ACT, 12'h123, 4'd5,  1'b1, 4'd1, 1'b0, 2'b01, 1'b0, 3'd0, 1'b0, 3'd2}, // R5
    '{C_ACT, 12'h855, 4'd5,  1'b1, 4'd1, 1'b0, 2'b11, 1'b0, 3'd0, 1'b0, 3'd2}, // R5
    '{C_RD,  12'h00A, 4'd7,  1'b1, 4'd2, 1'b0, 2'b11, 1'b0, 3'd0, 1'b0, 3'd2}, // R7
    '{C_WR,  12'hC07, 4'd7,  1'b1, 4'd3, 1'b1, 2'b01, 1'b0, 3'd0, 1'b0, 3'd2}, // R7
    '{C_RD,  12'h800, 4'd8,  1'b0, 4'd0, 1'b0, 2'b01, 1'b1, 3'd0, 1'b0, 3'd2}, // R8
    '{C_ACT, 12'h001, 4'd5,  1'b0, 4'd0, 1'b0, 2'b01, 1'b1, 3'd0, 1'b0, 3'd2}, // R5
    '{C_DES, 12'h001, 4'd2,  1'b0, 4'd0, 1'b0, 2'b01, 1'b0, 3'd0, 1'b0, 3'd2}, // R2
    '{C_BST, 12'h000, 4'd1,  1'b1, 4'd5, 1'b0, 2'b01, 1'b0, 3'd0, 1'b0, 3'd2}, // R1
    '{C_MRS, 12'h023, 4'd10, 1'b0, 4'd0, 1'b0, 2'b01, 1'b1, 3'd0, 1'b0, 3'd2}, // R10
    '{C_REF, 12'h000, 4'd12, 1'b0, 4'd0, 1'b0, 2'b01, 1'b1, 3'd0, 1'b0, 3'd2}, // R12
    '{C_PRE, 12'h000, 4'd6,  1'b1, 4'd4, 1'b0, 2'b00, 1'b0, 3'd0, 1'b0, 3'd2}, // R6
    '{C_PRE, 12'h800, 4'd6,  1'b1, 4'd4, 1'b0, 2'b00, 1'b0, 3'd0, 1'b0, 3'd2}, // R6
    '{C_MRS, 12'h03B, 4'd9,  1'b1, 4'd8, 1'b0, 2'b00, 1'b0, 3'd3, 1'b1, 3'd3}, // R9
    '{C_REF, 12'h000, 4'd3,  1'b1, 4'd6, 1'b0, 2'b00, 1'b0, 3'd3, 1'b1, 3'd3}, // R3
    '{C_ACT, 12'h000, 4'd5,  1'b1, 4'd1, 1'b0, 2'b01, 1'b0, 3'd3, 1'b1, 3'd3}, // R5
    '{C_ACT, 12'h800, 4'd5,  1'b1, 4'd1, 1'b0, 2'b11, 1'b0, 3'd3, 1'b1, 3'd3}, // R5
    '{C_PRE, 12'h400, 4'd6,  1'b1, 4'd4, 1'b0, 2'b00, 1'b0, 3'd3, 1'b1, 3'd3}, // R6
    '{C_MRS, 12'h012, 4'd11, 1'b1, 4'd8, 1'b0, 2'b00, 1'b1, 3'd2, 1'b0, 3'd1}, // R11
    '{C_MRS, 12'h027, 4'd11, 1'b1, 4'd8, 1'b0, 2'b00, 1'b0, 3'd7, 1'b0, 3'd2}, // R11
    '{C_MRS, 12'h02F, 4'd11, 1'b1, 4'd8, 1'b0, 2'b00, 1'b1, 3'd7, 1'b1, 3'd2}, // R11
    '{C_MRS, 12'h024, 4'd11, 1'b1, 4'd8, 1'b0, 2'b00, 1'b1, 3'd4, 1'b0, 3'd2}, // R11
    '{C_MRS, 12'h020, 4'd9,  1'b1, 4'd8, 1'b0, 2'b00, 1'b0, 3'd0, 1'b0, 3'd2}, // R9
    '{C_NOP, 12'h000, 4'd1,  1'b0, 4'd0, 1'b0, 2'b00, 1'b0, 3'd0, 1'b0, 3'd2}  // R1
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cke_i, cs_ni, ras_ni, cas_ni, we_ni;
  logic [11:0] addr_i;
  logic        cmd_valid_o, auto_pre_o, burst_seq_o, err_o;
  logic [3:0]  cmd_o;
  logic [0:0]  bank_o;
  logic [10:0] row_o;
  logic [7:0]  col_o;
  logic [1:0]  bank_open_o;
  logic [2:0]  burst_len_o, cas_lat_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sdram_cmd_tracker dut (
    .clk_i, .rst_ni, .cke_i, .cs_ni, .ras_ni, .cas_ni, .we_ni, .addr_i,
    .cmd_valid_o, .cmd_o, .bank_o, .row_o, .col_o, .auto_pre_o,
    .bank_open_o, .burst_len_o, .burst_seq_o, .cas_lat_o, .err_o
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on falling edge, sample a quarter period after the next rising edge
  task automatic step(input logic [4:0] ctl, input logic [11:0] a);
    @(negedge clk_i);
    {cke_i, cs_ni, ras_ni, cas_ni, we_ni} = ctl;
    addr_i = a;
    @(posedge clk_i);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    {cke_i, cs_ni, ras_ni, cas_ni, we_ni} = C_DES;
    addr_i = '0;
    repeat (3) @(posedge clk_i);
    #(CLK_PERIOD/4);
    // R13 reset state
    check("R13 reset", {cmd_valid_o, err_o, auto_pre_o, bank_open_o, cmd_o, burst_len_o, burst_seq_o, cas_lat_o},
          {1'b0, 1'b0, 1'b0, 2'b00, 4'd0, 3'd0, 1'b0, 3'd2});
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(C_NOP, 12'h000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ctl, VEC[i].addr);
      check($sformatf("R%0d row %0d state", VEC[i].req, i),
            {cmd_valid_o, bank_open_o, err_o, burst_len_o, burst_seq_o, cas_lat_o},
            {VEC[i].v, VEC[i].open, VEC[i].err, VEC[i].bl, VEC[i].bt, VEC[i].cl});
      if (VEC[i].v)
        check($sformatf("R%0d row %0d cmd", VEC[i].req, i), {cmd_o, auto_pre_o}, {VEC[i].cmd, VEC[i].ap});
    end

    // R3 refresh code with cke low now: self-refresh entry
    step({1'b0, C_REF[3:0]}, 12'h000);
    check("R3 sref", {cmd_valid_o, cmd_o, err_o}, {1'b1, 4'd7, 1'b0});
    // R3 cke was low at previous edge: activate ignored
    step(C_ACT, 12'h000);
    check("R3 cke gate", {cmd_valid_o, err_o, bank_open_o, cmd_o}, {1'b0, 1'b0, 2'b00, 4'd7});
    step(C_ACT, 12'h000);
    check("R3 cke back", {cmd_valid_o, cmd_o, bank_open_o}, {1'b1, 4'd1, 2'b01});

    // R4 address fields
    step(C_ACT, 12'hFFF);
    check("R4 act fields", {bank_o, row_o, bank_open_o}, {1'b1, 11'h7FF, 2'b11});
    step(C_RD, 12'h8C3);
    check("R4 rd fields", {bank_o, col_o, auto_pre_o, cmd_o}, {1'b1, 8'hC3, 1'b0, 4'd2});
    step(C_DES, 12'h35A);
    check("R4 hold", {bank_o, col_o, row_o, cmd_o}, {1'b1, 8'hC3, 11'h0C3, 4'd2});
    step(C_WR, 12'h45A);
    check("R7 wr autopre", {bank_o, col_o, auto_pre_o, bank_open_o}, {1'b0, 8'h5A, 1'b1, 2'b10});
    step(C_WR, 12'h05A);
    check("R8 wr closed", {cmd_valid_o, err_o, bank_open_o}, {1'b0, 1'b1, 2'b10});

    // R13 reset mid-run
    step(C_MRS, 12'h000);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #(CLK_PERIOD/4);
    check("R13 mid reset", {cmd_valid_o, err_o, bank_open_o, cmd_o, cas_lat_o}, {1'b0, 1'b0, 2'b00, 4'd0, 3'd2});
    rst_ni = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule